// File: doc/BRIEF.md
# Pipelined Binary Neural Layer Engine

This block evaluates one fully connected layer of a binary neural network on a stream of N-bit activation vectors. It accepts one vector per clock and copies it into P neuron lanes, where P is a fixed bit budget divided by N. Each lane XNORs its copy with that lane's stored weight word. It then counts the ones in the result with a log-depth mask-and-add tree and compares the count against half the vector width. The P sign bits are packed into one P-bit result word.

Weights are written one lane at a time through a separate load port. They are expected to stay unchanged while activation vectors are in flight. The engine has no backpressure. Every accepted vector yields exactly one result word after a fixed number of cycles, and results come out in the order the vectors went in. Narrow vectors therefore buy more neurons per cycle, and wide vectors buy longer dot products.

Top module: `bnn_layer_pipe`

## Requirements
- R1: While reset is asserted and on leaving it, `out_valid` is 0 and `out_y` is all zeros, and every lane's weight word is cleared to zero.
- R2: A vector presented with `in_valid` high at a rising edge appears as a result with `out_valid` high exactly 4 + 2·log2(N) edges later. There is exactly one result per accepted vector, in input order, and `out_valid` is never raised without a pending vector.
- R3: The engine has P = BUDGET/N lanes. Bit i of `out_y` is the decision of lane i, which uses weight word i.
- R4: The decision of a lane is 1 when the number of ones in XNOR(activation, weight) is greater than or equal to N/2, and 0 otherwise. A count of exactly N/2 gives 1.
- R5: A rising edge with `wt_we` high stores `wt_data` into the lane selected by `wt_lane` (binary lane index). The other lanes keep their weights.
- R6: While `out_valid` is low, `out_y` keeps the last result. A cycle with `in_valid` low produces no result, whatever `in_act` carries.
- R7: Vectors may be presented on every consecutive cycle with no stall. At most 4 + 2·log2(N) vectors are in flight at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Activation vector present this cycle |
| in_act | input | N | Activation vector |
| wt_we | input | 1 | Weight write strobe |
| wt_lane | input | LW | Lane index for the weight write (LW = log2 P, at least 1) |
| wt_data | input | N | Weight word for the addressed lane |
| out_valid | output | 1 | Result word present this cycle |
| out_y | output | P | Packed lane decisions, bit i from lane i |

## Verification
The bench builds the engine with N = 16 and BUDGET = 128, which gives eight lanes and a twelve-cycle latency. With a 16-bit vector, counts of exactly 8 and 7 are easy to reach on purpose, so both sides of the threshold are hit directly. Eight lanes are few enough to walk a one-hot pattern across every output bit. Random weights and gapped or back-to-back vector streams then run against an independent XNOR-count model, and each result's arrival cycle is checked against the latency.

// File: rtl/bnn_layer_pipe.sv
module bnn_layer_pipe #(
  parameter int N      = 32,
  parameter int BUDGET = 2048,
  localparam int P     = BUDGET / N,
  localparam int LOGN  = $clog2(N),
  localparam int LW    = (P > 1) ? $clog2(P) : 1,
  localparam int LAT   = 4 + 2 * LOGN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_act,
  input  logic         wt_we,
  input  logic [LW-1:0] wt_lane,
  input  logic [N-1:0] wt_data,
  output logic         out_valid,
  output logic [P-1:0] out_y
);

  function automatic logic [N-1:0] lvl_mask(input int l);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = ((i >> l) & 1) == 0;
    return m;
  endfunction

  logic [N-1:0] wt  [P];
  logic [N-1:0] rep [P];
  logic [LAT-1:0] vpipe;
  logic [P-1:0] sgn_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) wt[i] <= '0;
    end else begin
      for (int i = 0; i < P; i++)
        if (wt_we && wt_lane == LW'(i)) wt[i] <= wt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < P; i++) rep[i] <= in_act;
  end

  for (genvar g = 0; g < P; g++) begin : lane
    logic [N-1:0] xn;
    logic         sgn;

    always_ff @(posedge clk) xn <= ~(rep[g] ^ wt[g]);

    for (genvar l = 0; l < LOGN; l++) begin : lvl
      localparam logic [N-1:0] M = lvl_mask(l);
      logic [N-1:0] src, lo, hi, s;
      if (l == 0) begin : first
        assign src = xn;
      end else begin : chain
        assign src = lvl[l-1].s;
      end
      always_ff @(posedge clk) begin
        lo <= src & M;
        hi <= (src >> (1 << l)) & M;
        s  <= lo + hi;
      end
    end

    always_ff @(posedge clk) sgn <= (lvl[LOGN-1].s >= N'(N / 2));
    assign sgn_bus[g] = sgn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_y <= '0;
    else if (vpipe[LAT-2])   out_y <= sgn_bus;
  end

  assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/bnn_layer_pipe_chk.sv
module bnn_layer_pipe_chk #(
  parameter int N      = 32,
  parameter int BUDGET = 2048,
  localparam int P     = BUDGET / N,
  localparam int LAT   = 4 + 2 * $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [P-1:0] out_y
);

  logic [15:0] inflight;
  logic [15:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight  <= '0;
      since_rst <= '0;
    end else begin
      inflight <= inflight + 16'(in_valid) - 16'(out_valid);
      if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
    end
  end

  assert_valid_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 16'd0);

  assert_inflight_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 16'(LAT));

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_y));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> since_rst >= 16'(LAT - 1));

  assert_known_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));

endmodule

bind bnn_layer_pipe bnn_layer_pipe_chk #(.N(N), .BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/test_bnn_layer_pipe.sv
module test_bnn_layer_pipe;
  localparam int N = 16;
  localparam int BUDGET = 128;
  localparam int P = BUDGET / N;
  localparam int LW = $clog2(P);
  localparam int LAT = 4 + 2 * $clog2(N);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, wt_we = 0;
  logic [N-1:0] in_act = '0, wt_data = '0;
  logic [LW-1:0] wt_lane = '0;
  logic out_valid;
  logic [P-1:0] out_y;

  bnn_layer_pipe #(.N(N), .BUDGET(BUDGET)) i_bnn_layer_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_act(in_act),
    .wt_we(wt_we), .wt_lane(wt_lane), .wt_data(wt_data),
    .out_valid(out_valid), .out_y(out_y));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  longint cyc = 0;
  logic [N-1:0] mw [P];
  logic [P-1:0] q_y [$];
  longint q_t [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [P-1:0] model(input logic [N-1:0] a);
    logic [P-1:0] y;
    for (int i = 0; i < P; i++) y[i] = $countones(~(a ^ mw[i])) >= N / 2;
    return y;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_y.size() == 0) chk(0, "R2 unexpected result", out_y, 0);
      else begin
        logic [P-1:0] e;
        longint t;
        e = q_y.pop_front();
        t = q_t.pop_front();
        chk(out_y === e, "R4 lane decisions", out_y, e);
        chk(cyc - t == LAT, "R2 latency", cyc - t, LAT);
      end
    end
  end

  task automatic send(input logic [N-1:0] a);
    @(negedge clk);
    in_valid = 1; in_act = a;
    q_y.push_back(model(a));
    q_t.push_back(cyc);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic load(input int lane, input logic [N-1:0] w);
    @(negedge clk);
    wt_we = 1; wt_lane = LW'(lane); wt_data = w;
    mw[lane] = w;
    @(posedge clk);
    #1 wt_we = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_y.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(150000 * 10);
    fails++; tests++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [P-1:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < P; i++) mw[i] = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    chk(out_y == '0, "R1 reset data", out_y, 0);
    rst_n = 1;
    // R1 zero weights, R4 threshold edges: counts 16, 0, 8, 7, 9
    send(16'h0000); send(16'hFFFF); send(16'h00FF); send(16'h01FF); send(16'h007F);
    drain();
    chk(out_y == {P{1'b1}}, "R4 count 9 gives one", out_y, {P{1'b1}});
    // R6 hold with invalid inputs
    held = out_y;
    for (int k = 0; k < 2 * LAT; k++) begin
      @(negedge clk); in_act = N'($urandom);
      if (out_valid || out_y !== held) chk(0, "R6 hold", out_y, held);
    end
    chk(out_y === held, "R6 hold end", out_y, held);
    // R3/R5 one-hot lane walk
    for (int i = 0; i < P; i++) begin
      for (int j = 0; j < P; j++) load(j, (i == j) ? 16'hA5C3 : 16'h5A3C);
      send(16'hA5C3);
      drain();
      chk(out_y == P'(1) << i, "R3 lane order", out_y, P'(1) << i);
    end
    // R5 single-lane overwrite leaves others
    load(2, 16'h5A3C);
    send(16'hA5C3);
    drain();
    chk(out_y == P'(1) << (P - 1), "R5 single lane write", out_y, P'(1) << (P - 1));
    // R7 random streams, back-to-back and gapped
    for (int r = 0; r < 6; r++) begin
      for (int j = 0; j < P; j++) load(j, N'($urandom));
      for (int k = 0; k < 40; k++) begin
        if (r % 2 == 1 && $urandom_range(3) == 0) @(negedge clk);
        send(N'($urandom));
      end
      drain();
    end
    chk(q_y.size() == 0, "R2 all results seen", q_y.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule